// File: doc/BRIEF.md
# Quad Digital Potentiometer SPI Controller

This block is the serial slave front end of a four-channel digital potentiometer. A transfer opens when the active-low chip select falls. The controller then receives an identifier byte, an instruction byte and, for most instructions, a data byte, all MSB first. From these it reads or writes one of four 6-bit wiper positions or one of sixteen stored data registers, or it reports its busy status. One instruction starts an open-ended stepping mode. After it, every further serial clock moves the chosen wiper one position up or down, depending on the serial input level, until chip select rises.

Writes take effect only when chip select rises after every bit of the data byte has arrived. A write to a data register models a slow nonvolatile save. A busy flag stays high for a fixed number of system clock cycles, and during that time only the status read is honoured. The serial pins are asynchronous to the system clock. They pass through a synchronizer and are edge-detected, so the serial clock must be several times slower than the system clock.

The command state machine has eight states. IDLE waits for chip select to fall (start), which leads to GET_ID. GET_ID goes to GET_INSTR when the identifier matches (id_ok), or to SKIP when it does not (id_bad). GET_INSTR goes to GET_DATA for writes (wr_cmd), to SEND_DATA for reads (rd_cmd), to STEP for the stepping instruction (step_cmd), and to SKIP for unknown codes or for commands refused while busy (reject). GET_DATA and SEND_DATA go to HOLD when their byte is complete (byte_done). From any state except IDLE, a rising chip select returns to IDLE (end). When that end happens in HOLD after a write, the write is committed.

Top module: `spi_pot_ctrl`

## Requirements
- R1: The identifier byte must carry 010100 in bits 7..2 and the value of `addr_strap` in bits 1..0. Otherwise the whole transfer changes no wiper, no register and no status, and `so_o` stays 0.
- R2: In the instruction byte, bits 7..4 are the opcode, bits 3..2 select the data register and bits 1..0 select the pot. Only the selected pot or register is affected.
- R3: Opcode 1010 (write wiper) loads bits 5..0 of the data byte into the selected wiper when chip select rises. Bits 7..6 of the data byte are ignored. No wiper changes except through a commit or a step.
- R4: Opcode 1001 (read wiper) returns the byte {00, wiper} on `so_o` during the third byte, MSB first. `si` is sampled on rising SCK and `so_o` changes after falling SCK.
- R5: Opcode 1100 (write data register) stores bits 5..0 of the data byte in register [pot][reg] when chip select rises. Opcode 1011 (read data register) returns {00, value}.
- R6: If chip select rises before all 8 bits of the data byte have arrived, nothing is committed.
- R7: After opcode 0010 (step), each later SCK rising edge with `si`=1 adds one to the selected wiper, and each with `si`=0 subtracts one, until chip select rises.
- R8: Stepping saturates: an increase at 63 leaves 63, and a decrease at 0 leaves 0.
- R9: A committed data register write drives `wip_o` high for exactly SAVE_CYCLES system clock cycles.
- R10: Opcode 0101 (read status) returns a byte with bit 0 = busy flag and all other bits 0. It is honoured while busy.
- R11: While `wip_o` is high, every opcode other than read status is ignored until chip select rises. Reads return 0 and writes change nothing.
- R12: Any opcode not listed above is ignored until chip select rises: no state changes and `so_o` stays 0.
- R13: `so_oe` is low, and `so_o` is 0, whenever chip select is high. `so_oe` is high during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_strap | input | 2 | Device address strap compared with identifier bits 1..0 |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| sck | input | 1 | Serial clock (asynchronous, slow) |
| si | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the serial data pad (high = drive) |
| wiper_o | output | 24 | Four 6-bit wiper positions, pot 0 in bits 5..0 |
| wip_o | output | 1 | Save in progress flag |

## Verification
The first sign of a wrong state or a wrong captured field is at the ports. It shows up when chip select rises: a wiper is committed to the wrong pot, or a partial write is committed. It can also show up within one SCK period in stepping mode, as a wiper that moves by more than one or wraps at an end. A stuck busy counter shows as `wip_o` high for the wrong number of system cycles, and as status reads or refused commands that disagree with that flag. A read-path fault shows on `so_o` one falling SCK edge after the instruction byte completes, as a wrong bit or one shifted a position.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;
    localparam int WIPER_W   = 6;
    localparam int NUM_POT   = 4;
    localparam int NUM_REG   = 4;
    localparam int SEL_W     = 2;
    localparam int BYTE_W    = 8;
    localparam logic [5:0] ID_PREFIX = 6'b010100;

    typedef enum logic [3:0] {
        OP_STEP     = 4'b0010,
        OP_STATUS   = 4'b0101,
        OP_RD_WIPER = 4'b1001,
        OP_WR_WIPER = 4'b1010,
        OP_RD_REG   = 4'b1011,
        OP_WR_REG   = 4'b1100
    } pot_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GET_ID,
        S_GET_INSTR,
        S_GET_DATA,
        S_SEND_DATA,
        S_STEP,
        S_HOLD,
        S_SKIP
    } pot_state_e;
endpackage

// File: rtl/pot_sync.sv
module pot_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] lvl_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign lvl_o = chain_q[STAGES-1];
endmodule

// File: rtl/pot_regbank.sv
module pot_regbank
    import spi_pot_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_wiper,
    input  logic                       wr_bank,
    input  logic                       step,
    input  logic                       step_up,
    input  logic [SEL_W-1:0]           pot_sel,
    input  logic [SEL_W-1:0]           reg_sel,
    input  logic [WIPER_W-1:0]         wr_data,
    input  logic [SEL_W-1:0]           rd_pot,
    input  logic [SEL_W-1:0]           rd_reg,
    output logic [NUM_POT*WIPER_W-1:0] wiper_o,
    output logic [WIPER_W-1:0]         rd_wiper,
    output logic [WIPER_W-1:0]         rd_bank
);
    localparam int NUM_ENT = NUM_POT * NUM_REG;
    logic [NUM_ENT*WIPER_W-1:0] bank_flat;

    for (genvar p = 0; p < NUM_POT; p++) begin : g_pot
        logic [WIPER_W-1:0] pos_q;
        logic               hit;
        assign hit = (pot_sel == SEL_W'(p));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pos_q <= '0;
            end else if (hit && wr_wiper) begin
                pos_q <= wr_data;
            end else if (hit && step) begin
                if (step_up) pos_q <= (pos_q == '1) ? pos_q : pos_q + 1'b1;
                else         pos_q <= (pos_q == '0) ? pos_q : pos_q - 1'b1;
            end
        end
        assign wiper_o[p*WIPER_W +: WIPER_W] = pos_q;
    end

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
        logic [WIPER_W-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else if (wr_bank && ({pot_sel, reg_sel} == (2*SEL_W)'(e))) val_q <= wr_data;
        end
        assign bank_flat[e*WIPER_W +: WIPER_W] = val_q;
    end

    assign rd_wiper = wiper_o[rd_pot*WIPER_W +: WIPER_W];
    assign rd_bank  = bank_flat[{rd_pot, rd_reg}*WIPER_W +: WIPER_W];
endmodule

// File: rtl/pot_cmd_fsm.sv
module pot_cmd_fsm
    import spi_pot_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   addr_strap,
    input  logic               start_ev,
    input  logic               end_ev,
    input  logic               sck_rise,
    input  logic               sck_fall,
    input  logic               si_s,
    input  logic               busy,
    input  logic [WIPER_W-1:0] rd_wiper,
    input  logic [WIPER_W-1:0] rd_bank,
    output logic [SEL_W-1:0]   rd_pot,
    output logic [SEL_W-1:0]   rd_reg,
    output logic               so_q,
    output logic               commit_wiper,
    output logic               commit_reg,
    output logic               step_ev,
    output logic               step_up,
    output logic [SEL_W-1:0]   sel_pot,
    output logic [SEL_W-1:0]   sel_reg,
    output logic [WIPER_W-1:0] wr_data
);
    pot_state_e        state_q, state_d;
    logic [2:0]        cnt_q;
    logic [BYTE_W-1:0] sh_q, tx_q, byte_in;
    logic [3:0]        op_q, op_in;
    logic              shifting, byte_done, id_ok;
    pot_state_e        instr_next;

    assign byte_in   = {sh_q[BYTE_W-2:0], si_s};
    assign op_in     = byte_in[7:4];
    assign rd_pot    = byte_in[1:0];
    assign rd_reg    = byte_in[3:2];
    assign shifting  = state_q inside {S_GET_ID, S_GET_INSTR, S_GET_DATA, S_SEND_DATA};
    assign byte_done = shifting && sck_rise && (cnt_q == 3'd7);
    assign id_ok     = (byte_in[7:2] == ID_PREFIX) && (byte_in[1:0] == addr_strap);

    always_comb begin
        instr_next = S_SKIP;
        if (!busy || op_in == OP_STATUS) begin
            unique case (op_in)
                OP_WR_WIPER, OP_WR_REG:              instr_next = S_GET_DATA;
                OP_RD_WIPER, OP_RD_REG, OP_STATUS:   instr_next = S_SEND_DATA;
                OP_STEP:                             instr_next = S_STEP;
                default:                             instr_next = S_SKIP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (state_q != S_IDLE && end_ev) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:      if (start_ev)  state_d = S_GET_ID;
                S_GET_ID:    if (byte_done) state_d = id_ok ? S_GET_INSTR : S_SKIP;
                S_GET_INSTR: if (byte_done) state_d = instr_next;
                S_GET_DATA,
                S_SEND_DATA: if (byte_done) state_d = S_HOLD;
                S_STEP, S_HOLD, S_SKIP: state_d = state_q;
                default:     state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0; sh_q <= '0; tx_q <= '0; op_q <= '0; so_q <= 1'b0;
            sel_pot <= '0; sel_reg <= '0; wr_data <= '0;
            commit_wiper <= 1'b0; commit_reg <= 1'b0; step_ev <= 1'b0; step_up <= 1'b0;
        end else begin
            commit_wiper <= 1'b0;
            commit_reg   <= 1'b0;
            step_ev      <= 1'b0;
            if (state_q == S_IDLE && start_ev) begin
                cnt_q <= '0; sh_q <= '0; tx_q <= '0; so_q <= 1'b0; op_q <= '0;
            end
            if (shifting && sck_rise) begin
                sh_q  <= byte_in;
                cnt_q <= cnt_q + 3'd1;
            end
            if (state_q == S_GET_INSTR && byte_done) begin
                op_q    <= op_in;
                sel_pot <= byte_in[1:0];
                sel_reg <= byte_in[3:2];
                unique case (op_in)
                    OP_RD_WIPER: tx_q <= {{(BYTE_W-WIPER_W){1'b0}}, rd_wiper};
                    OP_RD_REG:   tx_q <= {{(BYTE_W-WIPER_W){1'b0}}, rd_bank};
                    OP_STATUS:   tx_q <= {{(BYTE_W-1){1'b0}}, busy};
                    default:     tx_q <= '0;
                endcase
            end
            if (state_q == S_GET_DATA && byte_done) wr_data <= byte_in[WIPER_W-1:0];
            if ((state_q == S_SEND_DATA || state_q == S_HOLD) && sck_fall) begin
                so_q <= tx_q[BYTE_W-1];
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            end
            if (state_q == S_STEP && sck_rise && !end_ev) begin
                step_ev <= 1'b1;
                step_up <= si_s;
            end
            if (state_q == S_HOLD && end_ev) begin
                commit_wiper <= (op_q == OP_WR_WIPER);
                commit_reg   <= (op_q == OP_WR_REG);
            end
        end
    end
endmodule

// File: rtl/spi_pot_ctrl.sv
module spi_pot_ctrl
    import spi_pot_pkg::*;
#(
    parameter int SAVE_CYCLES = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 addr_strap,
    input  logic                       cs_n,
    input  logic                       sck,
    input  logic                       si,
    output logic                       so_o,
    output logic                       so_oe,
    output logic [NUM_POT*WIPER_W-1:0] wiper_o,
    output logic                       wip_o
);
    localparam int CNT_W = $clog2(SAVE_CYCLES + 1);

    logic [2:0]         pins_s;
    logic [1:0]         prev_q;
    logic               cs_s, sck_s, si_s;
    logic               start_ev, end_ev, sck_rise, sck_fall;
    logic [SEL_W-1:0]   rd_pot, rd_reg, sel_pot, sel_reg;
    logic [WIPER_W-1:0] rd_wiper, rd_bank, wr_data;
    logic               so_q, commit_wiper, commit_reg, step_ev, step_up;
    logic [CNT_W-1:0]   save_cnt_q;

    pot_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i({cs_n, sck, si}), .lvl_o(pins_s)
    );

    assign {cs_s, sck_s, si_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b10;
        else        prev_q <= {cs_s, sck_s};
    end

    assign start_ev = !cs_s && prev_q[1];
    assign end_ev   = cs_s && !prev_q[1];
    assign sck_rise = !cs_s && sck_s && !prev_q[0];
    assign sck_fall = !cs_s && !sck_s && prev_q[0];

    pot_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap),
        .start_ev(start_ev), .end_ev(end_ev), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .si_s(si_s), .busy(wip_o), .rd_wiper(rd_wiper), .rd_bank(rd_bank),
        .rd_pot(rd_pot), .rd_reg(rd_reg), .so_q(so_q),
        .commit_wiper(commit_wiper), .commit_reg(commit_reg),
        .step_ev(step_ev), .step_up(step_up),
        .sel_pot(sel_pot), .sel_reg(sel_reg), .wr_data(wr_data)
    );

    pot_regbank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_wiper(commit_wiper), .wr_bank(commit_reg),
        .step(step_ev), .step_up(step_up), .pot_sel(sel_pot), .reg_sel(sel_reg),
        .wr_data(wr_data), .rd_pot(rd_pot), .rd_reg(rd_reg),
        .wiper_o(wiper_o), .rd_wiper(rd_wiper), .rd_bank(rd_bank)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 save_cnt_q <= '0;
        else if (commit_reg)        save_cnt_q <= CNT_W'(SAVE_CYCLES);
        else if (save_cnt_q != '0)  save_cnt_q <= save_cnt_q - 1'b1;
    end

    assign wip_o = (save_cnt_q != '0);
    assign so_oe = !cs_s;
    assign so_o  = so_oe && so_q;
endmodule

// File: rtl/pot_ctrl_checks.sv
module pot_ctrl_checks
    import spi_pot_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cs_n,
    input logic                       so_oe,
    input logic                       wip_o,
    input logic [NUM_POT*WIPER_W-1:0] wiper_o,
    input logic                       commit_wiper,
    input logic                       commit_reg,
    input logic                       step_ev,
    input logic                       step_up,
    input logic [SEL_W-1:0]           sel_pot
);
    p_oe_off_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

    p_wiper_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(commit_wiper) && !$past(step_ev)) |-> $stable(wiper_o));

    p_sat_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ev && step_up && wiper_o[sel_pot*WIPER_W +: WIPER_W] == '1)
        |=> wiper_o[$past(sel_pot)*WIPER_W +: WIPER_W] == '1);

    p_sat_bot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ev && !step_up && wiper_o[sel_pot*WIPER_W +: WIPER_W] == '0)
        |=> wiper_o[$past(sel_pot)*WIPER_W +: WIPER_W] == '0);

    p_wip_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_reg |=> wip_o);

    p_single_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit_wiper, commit_reg, step_ev}));

    p_commit_on_cs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_wiper || commit_reg) |-> cs_n);

    p_busy_no_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wip_o |-> !commit_reg);
endmodule

bind spi_pot_ctrl pot_ctrl_checks u_checks (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe), .wip_o(wip_o),
    .wiper_o(wiper_o), .commit_wiper(commit_wiper), .commit_reg(commit_reg),
    .step_ev(step_ev), .step_up(step_up), .sel_pot(sel_pot)
);

// File: tb/tb_spi_pot_ctrl.sv
module tb_spi_pot_ctrl;
    localparam int SAVE = 2000;
    localparam int HALF = 8;
    localparam logic [7:0] ID = 8'h52;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr_strap = 2'b10;
    logic        cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic        so_o, so_oe, wip_o;
    logic [23:0] wiper_o;
    int          n_chk = 0, n_fail = 0, wip_hi = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    spi_pot_ctrl #(.SAVE_CYCLES(SAVE)) dut (
        .clk(clk), .rst_n(rst_n), .addr_strap(addr_strap), .cs_n(cs_n), .sck(sck),
        .si(si), .so_o(so_o), .so_oe(so_oe), .wiper_o(wiper_o), .wip_o(wip_o)
    );

    always @(negedge clk) if (wip_o) wip_hi++;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pos(int p);
        return int'(wiper_o[p*6 +: 6]);
    endfunction

    task automatic wt(int n); repeat (n) @(negedge clk); endtask

    task automatic xbit(input logic b, output logic r);
        si = b; wt(HALF); r = so_o; sck = 1'b1; wt(HALF); sck = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            logic rb;
            xbit(b[i], rb);
            r[i] = rb;
        end
    endtask

    task automatic cs_lo; cs_n = 1'b0; wt(HALF); endtask
    task automatic cs_hi; wt(HALF); cs_n = 1'b1; wt(4*HALF); endtask

    task automatic cmd3(input logic [7:0] id, ins, dat, output logic [7:0] rd);
        logic [7:0] junk;
        cs_lo; xbyte(id, junk); xbyte(ins, junk); xbyte(dat, rd); cs_hi;
    endtask

    task automatic t_reset;
        chk("R13 reset oe", so_oe, 0);
        chk("R3 reset wipers", int'(wiper_o), 0);
        chk("R9 reset wip", wip_o, 0);
    endtask

    task automatic t_write_read;
        logic [7:0] rd, junk;
        cmd3(ID, 8'hA1, 8'hEA, rd);
        chk("R3 write pot1 top bits ignored", pos(1), 8'h2A);
        chk("R2 pot0 untouched", pos(0), 0);
        chk("R2 pot2/pot3 untouched", pos(2) + pos(3), 0);
        cs_lo; xbyte(ID, junk);
        chk("R13 oe during transfer", so_oe, 1);
        xbyte(8'h91, junk); xbyte(8'h00, rd); cs_hi;
        chk("R4 read wiper pot1", rd, 8'h2A);
        chk("R13 oe after cs high", so_oe, 0);
    endtask

    task automatic t_bad_id;
        logic [7:0] rd;
        cmd3(8'h51, 8'hA1, 8'h05, rd);
        chk("R1 wrong strap no write", pos(1), 8'h2A);
        cmd3(8'h92, 8'h91, 8'h00, rd);
        chk("R1 wrong prefix no read data", rd, 0);
    endtask

    task automatic t_partial;
        logic [7:0] junk;
        logic       b;
        cs_lo; xbyte(ID, junk); xbyte(8'hA2, junk);
        for (int i = 0; i < 4; i++) xbit(1'b1, b);
        cs_hi;
        chk("R6 partial write commits nothing", pos(2), 0);
    endtask

    task automatic t_save;
        logic [7:0] rd;
        wip_hi = 0;
        cmd3(ID, 8'hCB, 8'h15, rd);
        chk("R9 wip high after register write", wip_o, 1);
        cmd3(ID, 8'h50, 8'h00, rd);
        chk("R10 status while busy", rd, 8'h01);
        cmd3(ID, 8'h91, 8'h00, rd);
        chk("R11 read wiper refused while busy", rd, 0);
        cmd3(ID, 8'hA0, 8'h11, rd);
        chk("R11 write wiper refused while busy", pos(0), 0);
        for (int i = 0; i < 4*SAVE && wip_o; i++) wt(1);
        chk("R9 wip falls", wip_o, 0);
        chk("R9 busy length", wip_hi, SAVE);
        cmd3(ID, 8'h50, 8'h00, rd);
        chk("R10 status idle", rd, 0);
        cmd3(ID, 8'hBB, 8'h00, rd);
        chk("R5 read back register pot3 reg2", rd, 8'h15);
        cmd3(ID, 8'hB7, 8'h00, rd);
        chk("R5 neighbour register pot3 reg1", rd, 0);
    endtask

    task automatic t_step;
        logic [7:0] junk;
        logic       b;
        cs_lo; xbyte(ID, junk); xbyte(8'h20, junk);
        for (int i = 0; i < 5; i++) xbit(1'b1, b);
        chk("R7 five up steps", pos(0), 5);
        for (int i = 0; i < 2; i++) xbit(1'b0, b);
        chk("R7 two down steps", pos(0), 3);
        cs_hi;
        chk("R7 value kept after cs high", pos(0), 3);
        chk("R7 pot1 untouched by step", pos(1), 8'h2A);
    endtask

    task automatic t_saturate;
        logic [7:0] rd, junk;
        logic       b;
        cmd3(ID, 8'hA2, 8'd62, rd);
        cs_lo; xbyte(ID, junk); xbyte(8'h22, junk);
        for (int i = 0; i < 3; i++) xbit(1'b1, b);
        cs_hi;
        chk("R8 saturate at 63", pos(2), 63);
        cmd3(ID, 8'hA2, 8'd1, rd);
        cs_lo; xbyte(ID, junk); xbyte(8'h22, junk);
        for (int i = 0; i < 3; i++) xbit(1'b0, b);
        cs_hi;
        chk("R8 saturate at 0", pos(2), 0);
    endtask

    task automatic t_unknown;
        logic [7:0] rd;
        cmd3(ID, 8'hF1, 8'h3F, rd);
        chk("R12 unknown opcode no write", pos(1), 8'h2A);
        chk("R12 unknown opcode so stays 0", rd, 0);
    endtask

    initial begin
        wt(5); rst_n = 1'b1; wt(5);
        t_reset;
        t_write_read;
        t_bad_id;
        t_partial;
        t_save;
        t_step;
        t_saturate;
        t_unknown;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule